// File: doc/BRIEF.md
# Four-Lane Serializer with Half-Rate Monitor Taps

This block turns a 4-bit parallel word into a single serial bit stream at the system clock rate. A free-running 2-bit slot counter divides time into frames of four cycles. At the end of slot 3 of each frame, a latching stage captures all four lanes of `data_i` at once. During the next frame, the latched word passes through a two-level multiplexer tree. The first level has two half-rate branches. The odd branch carries lanes 3 and 1, and the even branch carries lanes 2 and 0. A final 2:1 selector interleaves the two branches at full rate. An output flip-flop then retimes the serial bit and drives it as a true signal and as its complement.

For debug and alignment the block also brings out:
- the two half-rate branch streams;
- the untimed full-rate selector output;
- a square-wave quarter-rate clock marker, which an upstream word source uses to present each word in step with the capture slot.

The quarter-rate clock marker is a 50%-duty square wave.

Top module: `ser4_serializer`

## Requirements
- R1: Slot 0 is the first cycle after reset release, and slots repeat 0,1,2,3. The word held on `data_i` in slot 3 of frame f is emitted on `ser_o` in the order lane 3, lane 2, lane 1, lane 0. These bits appear in slots 2 and 3 of frame f+1 and slots 0 and 1 of frame f+2, one bit per cycle. Lane 3 therefore appears two clock edges after the capture edge.
- R2: `mon_odd_o` carries only lanes 3 and 1. Lane 3 appears first, in slots 1 and 2 of the frame after capture. Lane 1 follows, in slot 3 and in slot 0 of the next frame. Each bit is held for two cycles.
- R3: `mon_even_o` carries lanes 2 and 0 with the same timing as `mon_odd_o`: lane 2 in slots 1 and 2, then lane 0 in slot 3 and the following slot 0.
- R4: `data_i` is sampled only at the end of slot 3. Values driven in slots 0, 1 or 2 have no effect on any output.
- R5: `mux_o` is the untimed tree output, and `ser_o` equals `mux_o` delayed by one clock. At every cycle, `mux_o` equals one of the two monitor streams.
- R6: From the first clock edge after reset release, `ser_n_o` is the complement of `ser_o`.
- R7: `clk_q_o` is high in slots 0 and 1 and low in slots 2 and 3, giving a period of four cycles.
- R8: While `rst_ni` is low (asynchronous, active-low), `ser_o`, `ser_n_o`, `mux_o`, `mon_odd_o` and `mon_even_o` are 0. The slot counter returns to slot 0, so `clk_q_o` is 1. The latched word is cleared.
- R9: The monitor streams change only at the edges that start slots 1 and 3. They never change at an edge where `clk_q_o` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 4 | Parallel lanes; bit 3 is serialized first |
| ser_o | output | 1 | Retimed serial output |
| ser_n_o | output | 1 | Complement of `ser_o` |
| mux_o | output | 1 | Untimed full-rate tree output |
| mon_odd_o | output | 1 | Half-rate branch stream (lanes 3, 1) |
| mon_even_o | output | 1 | Half-rate branch stream (lanes 2, 0) |
| clk_q_o | output | 1 | Quarter-rate clock marker |

## Verification
The bound checker covers the properties that hold on every cycle:
- the one-cycle relation between `mux_o` and `ser_o`;
- the complement pair;
- the quarter-rate marker's four-cycle period;
- the rule that the monitor streams stay still whenever the marker toggles;
- the cleared outputs during reset.

Lane order, the two-edge latency and the lane pairing on each branch depend on which word was captured. Only the bench can show these. It drives a table of patterns and then random words, compares every cycle against a frame model, corrupts `data_i` in the middle of each frame, and applies a reset partway through the run.

// File: rtl/ser4_pkg.sv
package ser4_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned SLOT_W = $clog2(LANES);
  localparam int unsigned HALF_LANES = LANES / 2;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [LANES-1:0] word_t;
  localparam slot_t LAST_SLOT = slot_t'(LANES - 1);
endpackage

// File: rtl/ser4_slot_gen.sv
module ser4_slot_gen
  import ser4_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_t slot_o,
  output logic  en_quarter_o,
  output logic  en_half_o,
  output logic  clk_q_o
);
  slot_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_q + slot_t'(1);
  end

  assign slot_o       = slot_q;
  assign en_quarter_o = (slot_q == LAST_SLOT);
  assign en_half_o    = ~slot_q[0];
  assign clk_q_o      = ~slot_q[SLOT_W-1];
endmodule

// File: rtl/ser4_lane_latch.sv
module ser4_lane_latch #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ser4_mux_tree.sv
module ser4_mux_tree
  import ser4_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_half_i,
  input  slot_t slot_i,
  input  word_t word_i,
  output logic  odd_o,
  output logic  even_o,
  output logic  mux_o
);
  logic [1:0] branch_q;  // [1] odd: lanes 3,1  [0] even: lanes 2,0

  for (genvar b = 0; b < 2; b++) begin : g_branch
    localparam int unsigned HI = HALF_LANES + b;
    localparam int unsigned LO = b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) branch_q[b] <= 1'b0;
      else if (en_half_i)
        // slot 0 edge loads the high lane, slot 2 edge the low lane
        branch_q[b] <= slot_i[SLOT_W-1] ? word_i[LO] : word_i[HI];
    end
  end

  assign odd_o  = branch_q[1];
  assign even_o = branch_q[0];
  assign mux_o  = slot_i[0] ? branch_q[1] : branch_q[0];
endmodule

// File: rtl/ser4_retimer.sv
module ser4_retimer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic qn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o  <= 1'b0;
      qn_o <= 1'b0;
    end else begin
      q_o  <= d_i;
      qn_o <= ~d_i;
    end
  end
endmodule

// File: rtl/ser4_serializer.sv
module ser4_serializer
  import ser4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] data_i,
  output logic             ser_o,
  output logic             ser_n_o,
  output logic             mux_o,
  output logic             mon_odd_o,
  output logic             mon_even_o,
  output logic             clk_q_o
);
  slot_t slot;
  logic  en_quarter, en_half;
  word_t word_q;

  ser4_slot_gen i_slot_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_o       (slot),
    .en_quarter_o (en_quarter),
    .en_half_o    (en_half),
    .clk_q_o      (clk_q_o)
  );

  ser4_lane_latch #(.WIDTH(LANES)) i_lane_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_quarter),
    .d_i    (data_i),
    .q_o    (word_q)
  );

  ser4_mux_tree i_mux_tree (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_half_i (en_half),
    .slot_i    (slot),
    .word_i    (word_q),
    .odd_o     (mon_odd_o),
    .even_o    (mon_even_o),
    .mux_o     (mux_o)
  );

  ser4_retimer i_retimer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mux_o),
    .q_o    (ser_o),
    .qn_o   (ser_n_o)
  );
endmodule

// File: rtl/ser4_checker.sv
module ser4_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_o,
  input logic ser_n_o,
  input logic mux_o,
  input logic mon_odd_o,
  input logic mon_even_o,
  input logic clk_q_o
);
  logic [1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              edges_q <= '0;
    else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end

  assert_retime_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q != 2'd0) |-> (ser_o == $past(mux_o)));

  assert_mux_from_branch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_o == mon_odd_o) || (mux_o == mon_even_o));

  assert_complement_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q != 2'd0) |-> (ser_n_o == !ser_o));

  assert_marker_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd2) |-> (clk_q_o != $past(clk_q_o, 2)));

  assert_reset_outputs_low_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!ser_o && !ser_n_o && !mux_o && !mon_odd_o && !mon_even_o && clk_q_o));

  assert_monitor_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edges_q != 2'd0) && (clk_q_o != $past(clk_q_o)))
      |-> ($stable(mon_odd_o) && $stable(mon_even_o)));
endmodule

bind ser4_serializer ser4_checker i_ser4_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_o      (ser_o),
  .ser_n_o    (ser_n_o),
  .mux_o      (mux_o),
  .mon_odd_o  (mon_odd_o),
  .mon_even_o (mon_even_o),
  .clk_q_o    (clk_q_o)
);

// File: tb/test_ser4_serializer.sv
module test_ser4_serializer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] data_i = 4'h0;
  logic       ser_o, ser_n_o, mux_o, mon_odd_o, mon_even_o, clk_q_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int NF = 48;
  localparam int NV = 8;
  // {word, odd pair {l3,l1}, even pair {l2,l0}}
  localparam logic [7:0] VEC [NV] = '{
    {4'b1010, 2'b11, 2'b00}, {4'b0101, 2'b00, 2'b11},
    {4'b1100, 2'b10, 2'b10}, {4'b0011, 2'b01, 2'b01},
    {4'b1111, 2'b11, 2'b11}, {4'b0000, 2'b00, 2'b00},
    {4'b1001, 2'b10, 2'b01}, {4'b0110, 2'b01, 2'b10}
  };

  logic [3:0] words [NF];

  ser4_serializer i_ser4_serializer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .ser_o      (ser_o),
    .ser_n_o    (ser_n_o),
    .mux_o      (mux_o),
    .mon_odd_o  (mon_odd_o),
    .mon_even_o (mon_even_o),
    .clk_q_o    (clk_q_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // serial-order bit at offset m from the first bit of frame 0
  function automatic logic ser_bit(input int m);
    if (m < 0 || m / 4 >= NF) return 1'b0;
    return words[m / 4][3 - (m % 4)];
  endfunction

  function automatic logic mon_bit(input int m, input bit odd);
    int f, s;
    if (m < 0 || m / 4 >= NF) return 1'b0;
    f = m / 4;
    s = m % 4;
    if (f < NV) return odd ? VEC[f][3 - s / 2] : VEC[f][1 - s / 2];
    return words[f][(odd ? 1 : 0) + (s < 2 ? 2 : 0)];
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++)
      words[f] = (f < NV) ? VEC[f][7:4] : 4'($urandom);

    // R8: outputs while reset held
    repeat (3) @(negedge clk_i);
    check(!ser_o && !ser_n_o && !mux_o, "R8 data outputs low", {ser_o, ser_n_o, mux_o}, 0);
    check(!mon_odd_o && !mon_even_o, "R8 monitors low", {mon_odd_o, mon_even_o}, 0);
    check(clk_q_o == 1'b1, "R8 marker high in reset", clk_q_o, 1);

    rst_ni = 1'b1;
    for (int n = 0; n < 4 * NF; n++) begin
      check(ser_o == ser_bit(n - 6), "R1 serial bit", ser_o, ser_bit(n - 6));
      check(mux_o == ser_bit(n - 5), "R5 mux tap", mux_o, ser_bit(n - 5));
      check(mon_odd_o == mon_bit(n - 5, 1'b1), "R2 odd monitor", mon_odd_o, mon_bit(n - 5, 1'b1));
      check(mon_even_o == mon_bit(n - 5, 1'b0), "R3 even monitor", mon_even_o, mon_bit(n - 5, 1'b0));
      check(clk_q_o == ((n % 4) < 2), "R7 marker", clk_q_o, int'((n % 4) < 2));
      if (n == 0) check(!ser_n_o, "R6 complement before first edge", ser_n_o, 0);
      else        check(ser_n_o == !ser_o, "R6 complement", ser_n_o, int'(!ser_o));
      // R4: corrupt data_i mid-frame, restore before capture slot
      case (n % 4)
        0: data_i = words[n / 4];
        1: data_i = ~words[n / 4];
        2: data_i = words[n / 4];
        default: ;
      endcase
      @(negedge clk_i);
    end

    // R8: asynchronous reset mid-run
    data_i = 4'hF;
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check(!ser_o && !ser_n_o && !mux_o && !mon_odd_o && !mon_even_o, "R8 async clear",
          {ser_o, ser_n_o, mux_o, mon_odd_o, mon_even_o}, 0);
    check(clk_q_o == 1'b1, "R8 slot restart", clk_q_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 latency: all-ones word captured at end of slot 3 shows on ser_o from cycle 6
    for (int n = 0; n < 10; n++) begin
      check(ser_o == (n >= 6), "R1 latency after reset", ser_o, int'(n >= 6));
      check(clk_q_o == ((n % 4) < 2), "R7 marker after reset", clk_q_o, int'((n % 4) < 2));
      @(negedge clk_i);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule